// File: doc/BRIEF.md
# Single-Bank DRAM Command Legality Tracker

This block follows one DRAM bank through its life cycle. It watches the four active-low command strobes and a bank-match flag, and decodes each clock edge into a command. It then moves a six-state machine through its states: Idle, Row Opening, Row Open, Read Burst, Write Burst and Row Closing. Programmable row-to-column and precharge delays control how long the bank stays in the two transitional states. A programmable burst length controls how long it stays in each burst state.

Every command addressed to the bank is checked against the current state. An illegal command raises a one-cycle violation pulse and causes no transition. A memory controller can place the block beside its command path as a protocol checker. A model can use it as a bank-state reference.

State transitions: Idle goes to Row Opening on ACTIVE and to Row Closing on PRECHARGE. Row Opening goes to Row Open when its delay expires. Row Open goes to Read Burst on READ, to Write Burst on WRITE and to Row Closing on PRECHARGE. Read Burst and Write Burst go to each other, or restart themselves, on READ or WRITE, and return to Row Open when the burst expires. Row Closing goes to Idle when its delay expires.

Top module: `dram_bank_guard`

## Requirements
- R1: After reset, state_o is 0 (Idle), violation_o is 0 and burst_busy_o is 0. The state codes are: Idle=0, Row Opening=1, Row Open=2, Read Burst=3, Write Burst=4, Row Closing=5.
- R2: The command is decoded from {cs_n,ras_n,cas_n,we_n} as follows: 1xxx is DESELECT, 0111 is NOP, 0011 is ACTIVE, 0101 is READ, 0100 is WRITE, 0010 is PRECHARGE, 0001 is AUTO REFRESH and 0000 is LOAD MODE.
- R3: ACTIVE in Idle enters Row Opening. The bank stays there for t_rcd cycles, with 0 treated as 1, and then enters Row Open.
- R4: PRECHARGE in Idle or Row Open enters Row Closing. The bank stays there for t_rp cycles, with 0 treated as 1, and then enters Idle.
- R5: In Row Opening or Row Closing, any addressed command other than NOP or DESELECT is a violation. The delay keeps running regardless.
- R6: In Row Open, READ enters Read Burst and WRITE enters Write Burst. ACTIVE, AUTO REFRESH and LOAD MODE are violations.
- R7: A burst state lasts burst_len cycles, with 0 treated as 1, and then returns to Row Open. burst_busy_o is high throughout. A READ or WRITE during a burst restarts the count in the matching burst state.
- R8: PRECHARGE during Read Burst or Write Burst is a violation and does not enter Row Closing.
- R9: AUTO REFRESH and LOAD MODE are accepted in Idle with no violation, and the bank stays Idle. READ or WRITE in Idle is a violation.
- R10: violation_o rises in the cycle after an illegal command and lasts exactly one cycle for each illegal command. The illegal command itself causes no state change.
- R11: When bank_hit is 0, or the command is DESELECT or NOP, the command produces no violation and no command-driven transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| bank_hit | input | 1 | The command addresses this bank |
| t_rcd | input | TW | Row-open delay in cycles |
| t_rp | input | TW | Precharge delay in cycles |
| burst_len | input | BW | Burst length in cycles |
| state_o | output | 3 | Current bank state code |
| violation_o | output | 1 | One-cycle pulse for an illegal command |
| burst_busy_o | output | 1 | High while a read or write burst runs |

## Verification
The stimulus walks the bank through each state and offers every command class in each state. This separates the legal transitions from the rejected ones.

Three kinds of stimulus test the timers:
- Commands issued in the middle of a delay show whether a rejected command disturbs the timer.
- Delays and burst lengths of 0 and 1 expose off-by-one errors in the counters.
- A burst restarted in its last cycle shows whether a reload takes priority over expiry.

Commands with bank_hit low, and DESELECT with don't-care strobes, confirm that the bank-match qualification works.

// File: rtl/bank_pkg.sv
package bank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_OPENING  = 3'd1,
        ST_OPEN     = 3'd2,
        ST_RD_BURST = 3'd3,
        ST_WR_BURST = 3'd4,
        ST_CLOSING  = 3'd5
    } bank_state_e;

    typedef enum logic [2:0] {
        OP_DESEL,
        OP_NOP,
        OP_ACT,
        OP_RD,
        OP_WR,
        OP_PRE,
        OP_REF,
        OP_LMR
    } bank_op_e;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
    import bank_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     bank_hit,
    output bank_op_e op_o
);

    bank_op_e raw_op;

    // Strobe pattern to operation.
    always_comb begin
        if (cs_n) begin
            raw_op = OP_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  raw_op = OP_NOP;
                3'b011:  raw_op = OP_ACT;
                3'b101:  raw_op = OP_RD;
                3'b100:  raw_op = OP_WR;
                3'b010:  raw_op = OP_PRE;
                3'b001:  raw_op = OP_REF;
                3'b000:  raw_op = OP_LMR;
                default: raw_op = OP_NOP;
            endcase
        end
    end

    // A command aimed at another bank is seen here as a NOP.
    assign op_o = bank_hit ? raw_op : OP_NOP;

endmodule

// File: rtl/bank_down_timer.sv
module bank_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Loadable down-counter that holds at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dram_bank_guard.sv
module dram_bank_guard
    import bank_pkg::*;
#(
    parameter int TW = 8,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          bank_hit,
    input  logic [TW-1:0] t_rcd,
    input  logic [TW-1:0] t_rp,
    input  logic [BW-1:0] burst_len,
    output logic [2:0]    state_o,
    output logic          violation_o,
    output logic          burst_busy_o
);

    localparam logic [TW-1:0] T_ONE = TW'(1);
    localparam logic [BW-1:0] B_ONE = BW'(1);

    bank_op_e    op;
    bank_state_e state_q, state_d;
    logic        illegal;
    logic        phase_load, phase_zero;
    logic [TW-1:0] phase_val;
    logic        burst_load, burst_zero;
    logic        violation_q;

    // The loaded value is one less than the cycle count, so the count runs down to zero.
    // A programmed value of zero is treated as one cycle.
    wire [TW-1:0] rcd_ld   = (t_rcd == '0) ? '0 : t_rcd - T_ONE;
    wire [TW-1:0] rp_ld    = (t_rp == '0) ? '0 : t_rp - T_ONE;
    wire [BW-1:0] burst_ld = (burst_len == '0) ? '0 : burst_len - B_ONE;

    bank_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .bank_hit (bank_hit),
        .op_o     (op)
    );

    // One timer serves both the row-open and the precharge delay.
    bank_down_timer #(.W(TW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .zero_o   (phase_zero)
    );

    bank_down_timer #(.W(BW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (burst_load),
        .load_val (burst_ld),
        .zero_o   (burst_zero)
    );

    wire quiet = (op == OP_DESEL) || (op == OP_NOP);

    // Next-state and command-legality logic.
    always_comb begin
        state_d    = state_q;
        illegal    = 1'b0;
        phase_load = 1'b0;
        phase_val  = rcd_ld;
        burst_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (op)
                    OP_ACT: begin
                        state_d    = ST_OPENING;
                        phase_load = 1'b1;
                        phase_val  = rcd_ld;
                    end
                    OP_PRE: begin
                        state_d    = ST_CLOSING;
                        phase_load = 1'b1;
                        phase_val  = rp_ld;
                    end
                    OP_RD, OP_WR: illegal = 1'b1;
                    default: ;
                endcase
            end
            ST_OPENING, ST_CLOSING: begin
                illegal = !quiet;
                if (phase_zero) begin
                    state_d = (state_q == ST_OPENING) ? ST_OPEN : ST_IDLE;
                end
            end
            ST_OPEN: begin
                unique case (op)
                    OP_RD: begin
                        state_d    = ST_RD_BURST;
                        burst_load = 1'b1;
                    end
                    OP_WR: begin
                        state_d    = ST_WR_BURST;
                        burst_load = 1'b1;
                    end
                    OP_PRE: begin
                        state_d    = ST_CLOSING;
                        phase_load = 1'b1;
                        phase_val  = rp_ld;
                    end
                    OP_ACT, OP_REF, OP_LMR: illegal = 1'b1;
                    default: ;
                endcase
            end
            ST_RD_BURST, ST_WR_BURST: begin
                if (op == OP_RD || op == OP_WR) begin
                    state_d    = (op == OP_RD) ? ST_RD_BURST : ST_WR_BURST;
                    burst_load = 1'b1;
                end else begin
                    illegal = !quiet;
                    if (burst_zero) begin
                        state_d = ST_OPEN;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            violation_q <= 1'b0;
        end else begin
            violation_q <= illegal;
        end
    end

    assign state_o      = state_q;
    assign violation_o  = violation_q;
    assign burst_busy_o = (state_q == ST_RD_BURST) || (state_q == ST_WR_BURST);

endmodule

// File: rtl/bank_guard_props.sv
module bank_guard_props (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       bank_hit,
    input logic [2:0] state_o,
    input logic       violation_o,
    input logic       burst_busy_o
);

    wire is_nop = !cs_n && ras_n && cas_n && we_n;
    wire is_pre = !cs_n && !ras_n && cas_n && !we_n;
    wire is_rd  = !cs_n && ras_n && !cas_n && we_n;

    assert_hush_when_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_hit || cs_n || is_nop) |=> !violation_o);

    assert_transit_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1 || state_o == 3'd5) && bank_hit && !cs_n && !is_nop) |=> violation_o);

    assert_pre_waits_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd3 || state_o == 3'd4) && bank_hit && is_pre)
        |=> (violation_o && state_o != 3'd5));

    assert_idle_exits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd5));

    assert_open_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && $past(state_o) != 3'd2)
        |-> ($past(state_o) == 3'd1 || $past(state_o) == 3'd3 || $past(state_o) == 3'd4));

    assert_read_starts_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && bank_hit && is_rd) |=> (burst_busy_o && state_o == 3'd3));

endmodule

bind dram_bank_guard bank_guard_props u_props (.*);

// File: tb/sim_dram_bank_guard.sv
module sim_dram_bank_guard;

    localparam int TW = 8;
    localparam int BW = 8;
    localparam logic [3:0] C_DES = 4'b1000, C_NOP = 4'b0111, C_ACT = 4'b0011,
                           C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                           C_REF = 4'b0001, C_LMR = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, bank_hit = 1'b0;
    logic [TW-1:0] t_rcd = 8'd3;
    logic [TW-1:0] t_rp = 8'd2;
    logic [BW-1:0] burst_len = 8'd4;
    wire [2:0] state_o;
    wire violation_o, burst_busy_o;

    always #5 clk = ~clk;

    dram_bank_guard #(.TW(TW), .BW(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank_hit(bank_hit), .t_rcd(t_rcd), .t_rp(t_rp),
        .burst_len(burst_len), .state_o(state_o), .violation_o(violation_o),
        .burst_busy_o(burst_busy_o)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int q_st[$];
    bit q_vi[$];
    bit q_bz[$];
    string q_tag[$];

    int m_st = 0, m_tm = 0, m_bc = 0;

    // Drives one command and pushes the expected result of the next edge.
    task automatic step(input logic [3:0] pins, input logic hit, input string tag);
        bit cmdv, ill, ltm, lbc;
        int nst, vtm, rcdv, rpv, blv;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins;
        bank_hit = hit;
        cmdv = hit && !pins[3] && (pins != C_NOP);
        rcdv = (t_rcd == 0) ? 0 : int'(t_rcd) - 1;
        rpv  = (t_rp == 0) ? 0 : int'(t_rp) - 1;
        blv  = (burst_len == 0) ? 0 : int'(burst_len) - 1;
        nst = m_st; ill = 0; ltm = 0; lbc = 0; vtm = 0;
        case (m_st)
            0: if (cmdv) begin
                if (pins == C_ACT) begin nst = 1; ltm = 1; vtm = rcdv; end
                else if (pins == C_PRE) begin nst = 5; ltm = 1; vtm = rpv; end
                else if (pins == C_RD || pins == C_WR) ill = 1;
            end
            1, 5: begin
                if (cmdv) ill = 1;
                if (m_tm == 0) nst = (m_st == 1) ? 2 : 0;
            end
            2: if (cmdv) begin
                if (pins == C_RD) begin nst = 3; lbc = 1; end
                else if (pins == C_WR) begin nst = 4; lbc = 1; end
                else if (pins == C_PRE) begin nst = 5; ltm = 1; vtm = rpv; end
                else ill = 1;
            end
            default: begin
                if (cmdv && (pins == C_RD || pins == C_WR)) begin
                    nst = (pins == C_RD) ? 3 : 4; lbc = 1;
                end else begin
                    if (cmdv) ill = 1;
                    if (m_bc == 0) nst = 2;
                end
            end
        endcase
        m_tm = ltm ? vtm : ((m_tm > 0) ? m_tm - 1 : 0);
        m_bc = lbc ? blv : ((m_bc > 0) ? m_bc - 1 : 0);
        m_st = nst;
        q_st.push_back(nst);
        q_vi.push_back(ill);
        q_bz.push_back(nst == 3 || nst == 4);
        q_tag.push_back(tag);
    endtask

    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) step(C_NOP, 1'b1, tag);
    endtask

    // Monitor: compares each edge's outputs with the queued expectation.
    always @(posedge clk) begin
        #2;
        if (q_st.size() > 0) begin
            int es; bit ev, eb; string t;
            es = q_st.pop_front(); ev = q_vi.pop_front();
            eb = q_bz.pop_front(); t = q_tag.pop_front();
            checks++;
            if (int'(state_o) != es || violation_o != ev || burst_busy_o != eb) begin
                fails++;
                $display("FAIL %s: state=%0d viol=%0d busy=%0d expected state=%0d viol=%0d busy=%0d",
                         t, state_o, violation_o, burst_busy_o, es, ev, eb);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (state_o != 3'd0 || violation_o || burst_busy_o) begin
            fails++;
            $display("FAIL R1: state=%0d viol=%0d busy=%0d expected 0 0 0",
                     state_o, violation_o, burst_busy_o);
        end
        rst_n = 1'b1;
        nops(2, "R1");
        // Idle-only commands and illegal accesses from Idle
        step(C_REF, 1'b1, "R9");
        step(C_LMR, 1'b1, "R9");
        step(C_RD, 1'b1, "R9");
        step(C_WR, 1'b1, "R9");
        step(C_NOP, 1'b1, "R10");
        // Open a row; rejected commands while it opens
        step(C_ACT, 1'b1, "R3");
        step(C_RD, 1'b1, "R5");
        step(C_RD, 1'b0, "R11");
        nops(2, "R3");
        // Row open: rejected and accepted commands
        step(C_ACT, 1'b1, "R6");
        step(C_REF, 1'b1, "R6");
        step(C_LMR, 1'b1, "R6");
        step(C_DES, 1'b1, "R11");
        step(C_RD, 1'b1, "R7");
        step(C_NOP, 1'b1, "R7");
        step(C_PRE, 1'b1, "R8");
        step(C_NOP, 1'b1, "R7");
        step(C_RD, 1'b1, "R7");
        nops(5, "R7");
        step(C_WR, 1'b1, "R7");
        step(C_PRE, 1'b1, "R8");
        step(C_RD, 1'b1, "R7");
        step(C_WR, 1'b1, "R7");
        nops(5, "R7");
        // Close the row; rejected command during precharge
        step(C_PRE, 1'b1, "R4");
        step(C_LMR, 1'b1, "R5");
        nops(3, "R4");
        step(C_PRE, 1'b0, "R11");
        step(4'b1010, 1'b1, "R11");
        // Zero-valued delays and burst behave as one cycle
        t_rcd = 8'd0; t_rp = 8'd0; burst_len = 8'd1;
        step(C_NOP, 1'b1, "R2");
        step(C_ACT, 1'b1, "R3");
        step(C_NOP, 1'b1, "R3");
        step(C_WR, 1'b1, "R7");
        step(C_NOP, 1'b1, "R7");
        step(C_PRE, 1'b1, "R4");
        nops(2, "R4");
        burst_len = 8'd0;
        step(C_PRE, 1'b1, "R4");
        nops(2, "R4");
        step(C_REF, 1'b1, "R2");
        nops(3, "R1");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule